// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address by walking a four-level radix table held in memory. A request carries the virtual address, the kind of access (load, store or instruction fetch) and whether the requester runs in user mode. Starting from the table base given on `root_base`, the walker reads one 64-bit entry per level over a memory port that has at most one access outstanding. At every level it checks the entry and, if the walk may continue through it, sets the entry's accessed flag. For a store it also sets the dirty flag of the final entry. Each update goes back to memory only when a flag actually changes.

Write and user permission are narrowed level by level as the AND of each entry's flags. They are judged once, at the final level. The walk ends with a one-cycle response pulse. The response carries the physical address, a 2-bit fault code and the level at which the walk stopped. Levels are numbered 0 (the root table) to 3 (the table that holds the page frame).

Top module: `ptw_walker`

## Requirements
- R1: The entry for level k is read at physical address `{table_frame, idx_k, 3'b000}`. `table_frame` is `root_base` for level 0 and bits 51..12 of the previous level's entry after that. `idx_k` is virtual address bits [47:39], [38:30], [29:21] and [20:12] for levels 0 to 3, taken in that order.
- R2: A walk that succeeds reports fault code 0 and level 3. Its physical address is bits 51..12 of the level-3 entry followed by virtual address bits [11:0].
- R3: If an entry has bit 0 (present) clear, the walk stops at that level with fault code 1. No later level is read, the entry is not written, and the reported physical address is zero.
- R4: A fetch (req_kind = 2) through a present entry with bit 63 set stops the walk at that level with fault code 3. Fault priority is not-present, then fetch-disabled, then protection. Loads and stores ignore bit 63.
- R5: Bit 1 (write allowed) and bit 2 (user allowed) are ANDed across all four levels. At level 3, a store (req_kind = 1) with the combined write flag clear, or a user-mode access with the combined user flag clear, ends with fault code 2 at level 3.
- R6: A present entry that passes its checks is written back with bit 5 (accessed) set, and only if bit 5 was clear before. An entry that faults is never written.
- R7: Bit 6 (dirty) is set only in the level-3 entry and only for a store. A store whose level-3 entry already has bits 5 and 6 set causes no write.
- R8: The memory port has at most one access in flight. Address, write enable and write data stay constant from the cycle mem_req rises until mem_ack. An entry's write-back is acknowledged before the next level's read is issued.
- R9: req_ready is high only while the walker is idle, and no memory access is issued then. resp_valid is high for exactly one cycle per walk. The response fields hold their values until the next response.
- R10: A supervisor-mode access may reach user pages, and a load or fetch may reach pages that are read-only at any level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted while req_ready is high |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 48 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access, 0 for supervisor |
| root_base | input | 40 | Frame number of the level-0 table |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for an entry write-back, 0 for an entry read |
| mem_addr | output | 52 | Byte address of the entry |
| mem_wdata | output | 64 | Updated entry for a write-back |
| mem_ack | input | 1 | One-cycle completion of the current access |
| mem_rdata | input | 64 | Entry value, valid with mem_ack on a read |
| resp_valid | output | 1 | One-cycle pulse marking the end of a walk |
| resp_paddr | output | 52 | Translated physical address, zero on a fault |
| resp_fault | output | 2 | 0 none, 1 not present, 2 protection, 3 fetch disabled |
| resp_level | output | 2 | Level at which the walk stopped |

## Verification
The first entry read starts in the cycle after a request is accepted. A read's value is captured on the mem_ack edge and judged in the next cycle, so a write-back or the next read begins one cycle after capture. resp_valid rises on the edge after the last judgement or after the last write-back acknowledge. The bench records every memory access in its responder and waits for resp_valid, sampling at the falling edge. It then checks the response, the exact sequence of reads and writes, and the table contents in its memory. One cycle later it confirms that the pulse has ended and that the response fields still hold. Responder latency is varied so that the R8 ordering is checked under slow acknowledges as well as immediate ones.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // entry flag positions (fixed by the table format)
    localparam int PTE_PRESENT  = 0;
    localparam int PTE_WRITE    = 1;
    localparam int PTE_USER     = 2;
    localparam int PTE_ACCESSED = 5;
    localparam int PTE_DIRTY    = 6;
    localparam int PTE_NOEXEC   = 63;

    // access kinds on req_kind
    localparam logic [1:0] KIND_LOAD  = 2'd0;
    localparam logic [1:0] KIND_STORE = 2'd1;
    localparam logic [1:0] KIND_FETCH = 2'd2;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2,
        FLT_NOEXEC = 2'd3
    } ptw_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EVAL  = 2'd2,
        ST_WRITE = 2'd3
    } ptw_state_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int LVL_W  = 2,
    localparam int VPN_W = IDX_W * LEVELS
) (
    input  logic [VPN_W-1:0] vpn,
    input  logic [LVL_W-1:0] level,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] slice [LEVELS];

    // level 0 takes the most significant index field
    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vpn[IDX_W*(LEVELS-1-g) +: IDX_W];
    end

    assign idx = slice[level];

endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
    import ptw_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_last,
    input  logic [1:0]       kind,
    input  logic             user,
    input  logic             rw_in,
    input  logic             us_in,
    output ptw_fault_e       fault,
    output logic             rw_out,
    output logic             us_out,
    output logic [PTE_W-1:0] pte_new,
    output logic             wb_need
);

    logic is_store;
    logic is_fetch;

    assign is_store = (kind == KIND_STORE);
    assign is_fetch = (kind == KIND_FETCH);
    assign rw_out   = rw_in & pte[PTE_WRITE];
    assign us_out   = us_in & pte[PTE_USER];

    always_comb begin
        if (!pte[PTE_PRESENT]) begin
            fault = FLT_ABSENT;
        end else if (is_fetch && pte[PTE_NOEXEC]) begin
            fault = FLT_NOEXEC;
        end else if (is_last && ((is_store && !rw_out) || (user && !us_out))) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
        end
    end

    always_comb begin
        pte_new = pte;
        pte_new[PTE_ACCESSED] = 1'b1;
        if (is_last && is_store) begin
            pte_new[PTE_DIRTY] = 1'b1;
        end
    end

    assign wb_need = (fault == FLT_NONE) && (pte_new != pte);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int PA_W   = 52,
    parameter int PTE_W  = 64,
    localparam int VA_W  = OFF_W + IDX_W * LEVELS,
    localparam int FN_W  = PA_W - OFF_W,
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic [FN_W-1:0]  root_base,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_ack,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_fault,
    output logic [LVL_W-1:0] resp_level
);

    localparam int VPN_W  = IDX_W * LEVELS;
    localparam int ESZ_W  = $clog2(PTE_W / 8);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        ptw_state_e       st;
        logic [LVL_W-1:0] lvl;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
        logic [1:0]       kind;
        logic             user;
        logic [FN_W-1:0]  tbl;
        logic [PTE_W-1:0] pte;
        logic             rw;
        logic             us;
        logic             done;
        logic [PA_W-1:0]  paddr;
        ptw_fault_e       fault;
        logic [LVL_W-1:0] flvl;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0] cur_idx;
    ptw_fault_e       ev_fault;
    logic             ev_rw;
    logic             ev_us;
    logic [PTE_W-1:0] ev_pte;
    logic             ev_wb;
    logic             is_last;
    logic [FN_W-1:0]  pte_frame;
    logic             go_next;

    ptw_index_sel #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .LVL_W  (LVL_W)
    ) u_idx (
        .vpn   (q.vpn),
        .level (q.lvl),
        .idx   (cur_idx)
    );

    ptw_pte_eval #(
        .PTE_W (PTE_W)
    ) u_eval (
        .pte     (q.pte),
        .is_last (is_last),
        .kind    (q.kind),
        .user    (q.user),
        .rw_in   (q.rw),
        .us_in   (q.us),
        .fault   (ev_fault),
        .rw_out  (ev_rw),
        .us_out  (ev_us),
        .pte_new (ev_pte),
        .wb_need (ev_wb)
    );

    assign is_last   = (q.lvl == LAST_LVL);
    assign pte_frame = q.pte[OFF_W +: FN_W];
    assign go_next   = ((q.st == ST_EVAL) && (ev_fault == FLT_NONE) && !ev_wb)
                    || ((q.st == ST_WRITE) && mem_ack);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_READ;
                    d.lvl  = '0;
                    d.vpn  = req_vaddr[VA_W-1:OFF_W];
                    d.off  = req_vaddr[OFF_W-1:0];
                    d.kind = req_kind;
                    d.user = req_user;
                    d.tbl  = root_base;
                    d.rw   = 1'b1;
                    d.us   = 1'b1;
                end
            end
            ST_READ: begin
                if (mem_ack) begin
                    d.pte = mem_rdata;
                    d.st  = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (ev_fault != FLT_NONE) begin
                    d.st    = ST_IDLE;
                    d.done  = 1'b1;
                    d.paddr = '0;
                    d.fault = ev_fault;
                    d.flvl  = q.lvl;
                end else begin
                    d.rw = ev_rw;
                    d.us = ev_us;
                    if (ev_wb) begin
                        d.pte = ev_pte;
                        d.st  = ST_WRITE;
                    end
                end
            end
            default: ;
        endcase

        if (go_next) begin
            if (is_last) begin
                d.st    = ST_IDLE;
                d.done  = 1'b1;
                d.paddr = {pte_frame, q.off};
                d.fault = FLT_NONE;
                d.flvl  = q.lvl;
            end else begin
                d.st  = ST_READ;
                d.lvl = q.lvl + 1'b1;
                d.tbl = pte_frame;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE);
    assign mem_req    = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we     = (q.st == ST_WRITE);
    assign mem_addr   = {q.tbl, cur_idx, {ESZ_W{1'b0}}};
    assign mem_wdata  = q.pte;
    assign resp_valid = q.done;
    assign resp_paddr = q.paddr;
    assign resp_fault = q.fault;
    assign resp_level = q.flvl;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int PA_W   = 52,
    parameter int PTE_W  = 64,
    parameter int LVL_W  = 2,
    parameter int LEVELS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata,
    input logic             mem_ack,
    input logic             resp_valid,
    input logic [PA_W-1:0]  resp_paddr,
    input logic [1:0]       resp_fault,
    input logic [LVL_W-1:0] resp_level
);

    a_r8_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |=> (resp_valid || ($stable(resp_paddr) && $stable(resp_fault) && $stable(resp_level))));

    a_r2_ok_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault == 2'd0) |-> (resp_level == LVL_W'(LEVELS - 1)));

    a_r3_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault != 2'd0) |-> (resp_paddr == '0));

    a_r6_wb_marks_used: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[0]));

endmodule

bind ptw_walker ptw_walker_chk #(
    .PA_W   (PA_W),
    .PTE_W  (PTE_W),
    .LVL_W  (LVL_W),
    .LEVELS (LEVELS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .resp_valid (resp_valid),
    .resp_paddr (resp_paddr),
    .resp_fault (resp_fault),
    .resp_level (resp_level)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

    localparam int CLK_PERIOD = 10;
    localparam int F_P = 1, F_RW = 2, F_US = 4, F_A = 8, F_D = 16, F_X = 32;
    localparam int FULL = F_P | F_RW | F_US;
    localparam logic [39:0] PG = 40'hAB_CDEF_0123;
    localparam logic [47:0] VA = {9'd3, 9'd5, 9'd7, 9'd9, 12'h2A5};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [39:0] root_base = 40'd1;
    logic        mem_req, mem_we;
    logic [51:0] mem_addr;
    logic [63:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        resp_valid;
    logic [51:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic [1:0]  resp_level;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user), .root_base(root_base),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault), .resp_level(resp_level)
    );

    // memory model: written only by this process
    logic [63:0] mem [256];
    logic [51:0] log_addr [32];
    logic        log_we [32];
    int          log_n = 0;
    int          bad_addr = 0;
    int          lat = 1;
    int          wait_cnt = 0;
    logic        hp_we = 1'b0, hp_clr = 1'b0;
    logic [7:0]  hp_idx = '0;
    logic [63:0] hp_data = '0;

    always @(posedge clk) begin
        if (hp_we) mem[hp_idx] <= hp_data;
        if (hp_clr) begin log_n = 0; bad_addr = 0; end
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_ack <= 1'b1;
                if (mem_addr[51:16] != '0 || mem_addr[11:7] != '0) bad_addr++;
                if (log_n < 32) begin
                    log_addr[log_n] = mem_addr;
                    log_we[log_n]   = mem_we;
                end
                log_n++;
                if (mem_we) mem[{mem_addr[15:12], mem_addr[6:3]}] <= mem_wdata;
                else mem_rdata <= mem[{mem_addr[15:12], mem_addr[6:3]}];
            end else begin
                wait_cnt++;
            end
        end
    end

    int checks = 0;
    int errors = 0;
    logic [51:0] r_paddr;
    logic [1:0]  r_fault, r_level;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] pte(input logic [39:0] fr, input int fl);
        logic [63:0] e = '0;
        e[51:12] = fr;
        e[0] = fl[0]; e[1] = fl[1]; e[2] = fl[2];
        e[5] = fl[3]; e[6] = fl[4]; e[63] = fl[5];
        return e;
    endfunction

    function automatic logic [51:0] ea(input int fr, input int idx);
        return 52'((fr << 12) | (idx << 3));
    endfunction

    function automatic logic [39:0] nxt(input int k);
        return (k == 3) ? PG : 40'(k + 2);
    endfunction

    function automatic int vidx(input int k);
        return 3 + 2 * k;
    endfunction

    task automatic poke(input int fr, input int idx, input logic [63:0] v);
        @(negedge clk);
        hp_we = 1'b1; hp_idx = 8'({fr[3:0], idx[3:0]}); hp_data = v;
        @(negedge clk);
        hp_we = 1'b0;
    endtask

    function automatic logic [63:0] peek(input int k);
        return mem[8'({4'(k + 1), 4'(vidx(k))})];
    endfunction

    task automatic chain(input int f0, input int f1, input int f2, input int f3);
        int fl [4];
        fl[0] = f0; fl[1] = f1; fl[2] = f2; fl[3] = f3;
        for (int k = 0; k < 4; k++) poke(k + 1, vidx(k), pte(nxt(k), fl[k]));
    endtask

    task automatic walk(input logic [1:0] kind, input logic user);
        int n = 0;
        @(negedge clk);
        hp_clr = 1'b1;
        @(negedge clk);
        hp_clr = 1'b0;
        while (!req_ready && n < 500) begin @(negedge clk); n++; end
        req_vaddr = VA; req_kind = kind; req_user = user; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!resp_valid && n < 500) begin @(negedge clk); n++; end
        chk(resp_valid, "R9 walk completes", 64'(resp_valid), 64'd1);
        r_paddr = resp_paddr; r_fault = resp_fault; r_level = resp_level;
        @(negedge clk);
        chk(!resp_valid, "R9 response is one pulse", 64'(resp_valid), 64'd0);
        chk(resp_paddr == r_paddr && resp_fault == r_fault, "R9 response held",
            64'(resp_paddr), 64'(r_paddr));
        chk(bad_addr == 0, "R1 address inside modelled tables", 64'(bad_addr), 64'd0);
    endtask

    task automatic expect_resp(input string tag, input logic [1:0] f, input logic [1:0] lv, input logic [51:0] pa);
        chk(r_fault == f, {tag, " fault"}, 64'(r_fault), 64'(f));
        chk(r_level == lv, {tag, " level"}, 64'(r_level), 64'(lv));
        chk(r_paddr == pa, {tag, " paddr"}, 64'(r_paddr), 64'(pa));
    endtask

    // reads only, one per level from 0 to last
    task automatic expect_reads(input string tag, input int last);
        chk(log_n == last + 1, {tag, " access count"}, 64'(log_n), 64'(last + 1));
        for (int k = 0; k <= last && k < log_n; k++) begin
            chk(log_addr[k] == ea(k + 1, vidx(k)) && !log_we[k], {tag, " read address"},
                64'(log_addr[k]), 64'(ea(k + 1, vidx(k))));
        end
    endtask

    task automatic t_reset;
        chk(req_ready, "R9 ready after reset", 64'(req_ready), 64'd1);
        chk(!resp_valid && !mem_req, "R9 quiet after reset", 64'({resp_valid, mem_req}), 64'd0);
        chk(resp_fault == 2'd0, "R9 fault clear after reset", 64'(resp_fault), 64'd0);
    endtask

    task automatic t_first_walk;
        lat = 0;
        chain(FULL, FULL, FULL, FULL);
        walk(2'd0, 1'b1);
        expect_resp("R2 first load", 2'd0, 2'd3, {PG, 12'h2A5});
        chk(log_n == 8, "R8 read and write-back per level", 64'(log_n), 64'd8);
        for (int k = 0; k < 4 && 2 * k + 1 < log_n; k++) begin
            chk(log_addr[2*k] == ea(k + 1, vidx(k)) && !log_we[2*k], "R1 level read address",
                64'(log_addr[2*k]), 64'(ea(k + 1, vidx(k))));
            chk(log_addr[2*k+1] == ea(k + 1, vidx(k)) && log_we[2*k+1], "R8 write-back before next read",
                64'(log_addr[2*k+1]), 64'(ea(k + 1, vidx(k))));
            chk(peek(k) == pte(nxt(k), FULL | F_A), "R6 accessed set, R7 no dirty on load",
                peek(k), pte(nxt(k), FULL | F_A));
        end
    endtask

    task automatic t_repeat_walk;
        lat = 3;
        walk(2'd0, 1'b0);
        expect_resp("R2 repeat load", 2'd0, 2'd3, {PG, 12'h2A5});
        expect_reads("R6 no write when accessed already set", 3);
    endtask

    task automatic t_store;
        lat = 2;
        chain(FULL | F_A, FULL | F_A, FULL | F_A, FULL | F_A);
        walk(2'd1, 1'b1);
        expect_resp("R2 store", 2'd0, 2'd3, {PG, 12'h2A5});
        chk(log_n == 5, "R7 single dirty write", 64'(log_n), 64'd5);
        chk(log_addr[4] == ea(4, vidx(3)) && log_we[4], "R7 dirty write to last entry",
            64'(log_addr[4]), 64'(ea(4, vidx(3))));
        chk(peek(3) == pte(PG, FULL | F_A | F_D), "R7 dirty bit set", peek(3), pte(PG, FULL | F_A | F_D));
        chk(peek(2) == pte(nxt(2), FULL | F_A), "R7 upper entry not dirtied", peek(2), pte(nxt(2), FULL | F_A));
        walk(2'd1, 1'b1);
        expect_reads("R7 store to dirty page needs no write", 3);
    endtask

    task automatic t_absent;
        lat = 1;
        chain(FULL | F_A, FULL | F_A, F_RW | F_US | F_X, FULL | F_A);
        walk(2'd0, 1'b0);
        expect_resp("R3 not present", 2'd1, 2'd2, 52'd0);
        expect_reads("R3 stops at absent level", 2);
        chk(peek(2) == pte(nxt(2), F_RW | F_US | F_X), "R3 absent entry unchanged",
            peek(2), pte(nxt(2), F_RW | F_US | F_X));
        walk(2'd2, 1'b0);
        expect_resp("R4 absent outranks fetch-disable", 2'd1, 2'd2, 52'd0);
    endtask

    task automatic t_noexec;
        lat = 0;
        chain(FULL | F_A, FULL | F_A | F_X, FULL | F_A, FULL | F_A);
        walk(2'd2, 1'b1);
        expect_resp("R4 fetch disabled", 2'd3, 2'd1, 52'd0);
        expect_reads("R4 fetch stops at level", 1);
        walk(2'd0, 1'b1);
        expect_resp("R4 load ignores fetch-disable", 2'd0, 2'd3, {PG, 12'h2A5});
    endtask

    task automatic t_readonly;
        lat = 2;
        chain(F_P | F_US | F_A, FULL | F_A, FULL | F_A, FULL | F_A);
        walk(2'd1, 1'b0);
        expect_resp("R5 store through read-only root", 2'd2, 2'd3, 52'd0);
        expect_reads("R5 no write on protection fault", 3);
        chk(peek(3) == pte(PG, FULL | F_A), "R6 faulting entry not written", peek(3), pte(PG, FULL | F_A));
        walk(2'd0, 1'b1);
        expect_resp("R10 load of read-only page", 2'd0, 2'd3, {PG, 12'h2A5});
        walk(2'd2, 1'b1);
        expect_resp("R10 fetch of read-only page", 2'd0, 2'd3, {PG, 12'h2A5});
    endtask

    task automatic t_supervisor_only;
        lat = 1;
        chain(FULL | F_A, FULL | F_A, F_P | F_RW | F_A, FULL);
        walk(2'd0, 1'b1);
        expect_resp("R5 user through supervisor entry", 2'd2, 2'd3, 52'd0);
        expect_reads("R6 faulting last entry not marked", 3);
        chk(peek(3) == pte(PG, FULL), "R6 no accessed bit after fault", peek(3), pte(PG, FULL));
        walk(2'd1, 1'b0);
        expect_resp("R10 supervisor store", 2'd0, 2'd3, {PG, 12'h2A5});
        chk(peek(3) == pte(PG, FULL | F_A | F_D), "R6 R7 both flags in one write",
            peek(3), pte(PG, FULL | F_A | F_D));
        chk(log_n == 5, "R6 single write for both flags", 64'(log_n), 64'd5);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_walk();
        t_repeat_walk();
        t_store();
        t_absent();
        t_noexec();
        t_readonly();
        t_supervisor_only();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule